// File: doc/BRIEF.md
# Encoded fault flag manager

This block gathers the protection signals of a three-phase motor driver and turns them into three results: a drive-disable request for the power stage, a one-cycle restart request for the commutation logic, and a two-bit status code on a pair of flag pins. The protection signals are thermal shutdown, loss of rotor synchronisation, a drain-source overcurrent comparator, supply undervoltage, supply overvoltage and gate-supply undervoltage. The block also takes the internal run command, a pulse that marks an off-to-on change of that command, two configuration masks and a 6-bit lock-time setting.

Voltage faults do not latch and clear as soon as their comparator releases. Thermal shutdown and loss of sync start a lock timer, and the block requests a restart when the timer runs out. The timer starts again if the thermal condition is still present when it runs out. An overcurrent that lasts through a blanking window is latched. Only a new off-to-on command or reset clears it. The flag code always shows the most severe fault that is present. While the power-on delay is active the flags stay quiet.

Top module: `fault_flag_mgr`

## Requirements
- R1: `flag_o` (bit 1 = upper flag pin, bit 0 = lower) encodes 2'b00 no fault, 2'b01 thermal, 2'b10 lead fault or lock timer running, 2'b11 voltage fault. The priority order is voltage, then lead/lock, then thermal.
- R2: A supply undervoltage, or a supply overvoltage that is not disabled, gives flag 2'b11 and drive-disable one clock after it is sampled. Both clear one clock after the input releases.
- R3: Gate-supply undervoltage always disables the drive. It raises flag 2'b11 only while `run_cmd_i` is high.
- R4: `cfg_uv_mask_i` = 1 stops supply undervoltage from disabling the drive, but the flag still shows 2'b11. `cfg_ov_dis_i` = 1 removes supply overvoltage from both the flag and the drive-disable.
- R5: While `run_cmd_i` is high, thermal shutdown or loss of sync starts a lock timer of max(`cfg_lock_time_i`,1) × LOCK_UNIT clocks. The drive stays disabled and the flag shows 2'b10 for that whole time. When the timer expires with the thermal input low, `restart_o` pulses high for exactly one clock.
- R6: If thermal shutdown is still high when the timer expires, the timer reloads and no restart pulse is issued.
- R7: With the command on, a new thermal shutdown first shows 2'b01 for one clock and then 2'b10.
- R8: A low `run_cmd_i` clears the lock timer and blocks any restart pulse. If the thermal input is still high, the flag moves from 2'b10 to 2'b01 two clocks after the command drops.
- R9: The overcurrent latch sets only after `ocp_i` has been high for BLANK_CYCLES consecutive clocks. A shorter burst has no effect.
- R10: The overcurrent latch holds flag 2'b10 and drive-disable until a `run_rise_i` pulse or reset, even after a low command. If the clear pulse and the end of the blanking window fall on the same clock, the clear wins.
- R11: While `por_busy_i` is high, the flag shows 2'b00 and the drive is disabled.
- R12: After reset, `flag_o` = 2'b00, `drv_off_o` = 0 and `restart_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_busy_i | input | 1 | Power-on delay in progress |
| tsd_i | input | 1 | Thermal shutdown comparator |
| sync_lost_i | input | 1 | Loss-of-synchronisation event |
| ocp_i | input | 1 | Drain-source overcurrent comparator |
| vbb_uv_i | input | 1 | Supply undervoltage |
| vbb_ov_i | input | 1 | Supply overvoltage |
| vcp_uv_i | input | 1 | Gate-supply undervoltage |
| run_cmd_i | input | 1 | Internal motor run command |
| run_rise_i | input | 1 | One-clock pulse on an off-to-on command change |
| cfg_uv_mask_i | input | 1 | Keep supply undervoltage from disabling the drive |
| cfg_ov_dis_i | input | 1 | Ignore supply overvoltage |
| cfg_lock_time_i | input | LOCK_W | Lock time in LOCK_UNIT clocks (0 counts as 1) |
| drv_off_o | output | 1 | Power-stage disable request |
| restart_o | output | 1 | One-clock restart request at lock expiry |
| flag_o | output | 2 | Encoded fault status |

## Verification
The off-to-on clear pulse can arrive on the same clock that the overcurrent blanking window completes. In that case the latch both sets and clears on one edge. The bench keeps `ocp_i` high for exactly BLANK_CYCLES clocks and places `run_rise_i` on the last of them. It then expects the flag to stay at 2'b00 and the drive to stay enabled, because the clear wins. The bench also runs a lock timer while the thermal input stays high and drops the command in the middle of it. This checks that the timer reset and the thermal flag take effect together and that no restart escapes.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic [1:0] {
    FLG_CLEAR = 2'b00,
    FLG_THERM = 2'b01,
    FLG_LEAD  = 2'b10,
    FLG_VOLT  = 2'b11
  } flag_e;
endpackage

// File: rtl/ffm_lock_timer.sv
module ffm_lock_timer #(
  parameter int LOCK_W    = 6,
  parameter int LOCK_UNIT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              trig_i,
  input  logic              hold_i,
  input  logic [LOCK_W-1:0] cfg_i,
  output logic              active_o,
  output logic              restart_o
);
  localparam int MAX_CNT = ((1 << LOCK_W) - 1) * LOCK_UNIT;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  load_val;
  logic [LOCK_W-1:0] units;

  // a zero setting is treated as one time unit
  always_comb begin
    units    = (cfg_i == '0) ? LOCK_W'(1) : cfg_i;
    load_val = CNT_W'(units) * CNT_W'(LOCK_UNIT) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o  <= 1'b0;
      restart_o <= 1'b0;
      cnt       <= '0;
    end else begin
      restart_o <= 1'b0;
      if (!run_i) begin
        active_o <= 1'b0;
        cnt      <= '0;
      end else if (!active_o) begin
        if (trig_i) begin
          active_o <= 1'b1;
          cnt      <= load_val;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end else if (hold_i) begin
        cnt <= load_val;
      end else begin
        active_o  <= 1'b0;
        restart_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ffm_ocp_latch.sv
module ffm_ocp_latch #(
  parameter int BLANK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ocp_i,
  input  logic clr_i,
  output logic latched_o
);
  localparam int BW = $clog2(BLANK_CYCLES + 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt       <= '0;
      latched_o <= 1'b0;
    end else if (!ocp_i) begin
      cnt <= '0;
    end else if (cnt == BW'(BLANK_CYCLES - 1)) begin
      latched_o <= 1'b1;
    end else begin
      cnt <= cnt + BW'(1);
    end
  end
endmodule

// File: rtl/ffm_flag_enc.sv
module ffm_flag_enc
  import flt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por_i,
  input  logic       volt_flag_i,
  input  logic       volt_off_i,
  input  logic       lead_i,
  input  logic       therm_i,
  output logic [1:0] flag_o,
  output logic       drv_off_o
);
  flag_e flag_nx;
  logic  off_nx;

  always_comb begin
    if (por_i)            flag_nx = FLG_CLEAR;
    else if (volt_flag_i) flag_nx = FLG_VOLT;
    else if (lead_i)      flag_nx = FLG_LEAD;
    else if (therm_i)     flag_nx = FLG_THERM;
    else                  flag_nx = FLG_CLEAR;
    off_nx = por_i | volt_off_i | lead_i | therm_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o    <= FLG_CLEAR;
      drv_off_o <= 1'b0;
    end else begin
      flag_o    <= flag_nx;
      drv_off_o <= off_nx;
    end
  end
endmodule

// File: rtl/fault_flag_mgr.sv
module fault_flag_mgr #(
  parameter int LOCK_W       = 6,
  parameter int LOCK_UNIT    = 1000,
  parameter int BLANK_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_busy_i,
  input  logic              tsd_i,
  input  logic              sync_lost_i,
  input  logic              ocp_i,
  input  logic              vbb_uv_i,
  input  logic              vbb_ov_i,
  input  logic              vcp_uv_i,
  input  logic              run_cmd_i,
  input  logic              run_rise_i,
  input  logic              cfg_uv_mask_i,
  input  logic              cfg_ov_dis_i,
  input  logic [LOCK_W-1:0] cfg_lock_time_i,
  output logic              drv_off_o,
  output logic              restart_o,
  output logic [1:0]        flag_o
);
  logic ocp_lat;
  logic lock_act;
  logic ov_live;
  logic volt_flag;
  logic volt_off;

  always_comb begin
    ov_live   = vbb_ov_i & ~cfg_ov_dis_i;
    volt_flag = vbb_uv_i | ov_live | (vcp_uv_i & run_cmd_i);
    volt_off  = (vbb_uv_i & ~cfg_uv_mask_i) | ov_live | vcp_uv_i;
  end

  ffm_lock_timer #(.LOCK_W(LOCK_W), .LOCK_UNIT(LOCK_UNIT)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_cmd_i),
    .trig_i    (tsd_i | sync_lost_i),
    .hold_i    (tsd_i),
    .cfg_i     (cfg_lock_time_i),
    .active_o  (lock_act),
    .restart_o (restart_o)
  );

  ffm_ocp_latch #(.BLANK_CYCLES(BLANK_CYCLES)) u_ocp (
    .clk       (clk),
    .rst       (rst),
    .ocp_i     (ocp_i),
    .clr_i     (run_rise_i),
    .latched_o (ocp_lat)
  );

  ffm_flag_enc u_enc (
    .clk         (clk),
    .rst         (rst),
    .por_i       (por_busy_i),
    .volt_flag_i (volt_flag),
    .volt_off_i  (volt_off),
    .lead_i      (ocp_lat | lock_act),
    .therm_i     (tsd_i),
    .flag_o      (flag_o),
    .drv_off_o   (drv_off_o)
  );
endmodule

// File: rtl/fault_flag_mgr_chk.sv
module fault_flag_mgr_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_busy_i,
  input logic       tsd_i,
  input logic       vbb_uv_i,
  input logic       vbb_ov_i,
  input logic       vcp_uv_i,
  input logic       run_cmd_i,
  input logic       run_rise_i,
  input logic       cfg_ov_dis_i,
  input logic       ocp_lat,
  input logic       lock_act,
  input logic       drv_off_o,
  input logic       restart_o,
  input logic [1:0] flag_o
);
  AST_POR_QUIET: assert property (@(posedge clk) disable iff (rst)
    por_busy_i |=> (flag_o == 2'b00) && drv_off_o); // R11

  AST_VOLT_TOP: assert property (@(posedge clk) disable iff (rst)
    (!por_busy_i && vbb_uv_i) |=> flag_o == 2'b11); // R1

  AST_GATE_UV_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (!por_busy_i && !run_cmd_i && !vbb_uv_i && !(vbb_ov_i && !cfg_ov_dis_i))
      |=> flag_o != 2'b11); // R3

  AST_OV_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!por_busy_i && cfg_ov_dis_i && vbb_ov_i && !vbb_uv_i && !vcp_uv_i &&
     !ocp_lat && !lock_act && !tsd_i) |=> !drv_off_o); // R4

  AST_OCP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    run_rise_i |=> !ocp_lat); // R10

  AST_LEAD_DISABLES: assert property (@(posedge clk) disable iff (rst)
    ocp_lat |=> drv_off_o); // R10

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o); // R5

  AST_NO_RESTART_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_cmd_i |=> !restart_o); // R8
endmodule

bind fault_flag_mgr fault_flag_mgr_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .por_busy_i   (por_busy_i),
  .tsd_i        (tsd_i),
  .vbb_uv_i     (vbb_uv_i),
  .vbb_ov_i     (vbb_ov_i),
  .vcp_uv_i     (vcp_uv_i),
  .run_cmd_i    (run_cmd_i),
  .run_rise_i   (run_rise_i),
  .cfg_ov_dis_i (cfg_ov_dis_i),
  .ocp_lat      (ocp_lat),
  .lock_act     (lock_act),
  .drv_off_o    (drv_off_o),
  .restart_o    (restart_o),
  .flag_o       (flag_o)
);

// File: tb/fault_flag_mgr_tb.sv
module fault_flag_mgr_tb;
  localparam int LOCK_W    = 6;
  localparam int LOCK_UNIT = 4;
  localparam int BLANK     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_busy = 0, tsd = 0, sync_lost = 0, ocp = 0;
  logic vbb_uv = 0, vbb_ov = 0, vcp_uv = 0, run_cmd = 0, run_rise = 0;
  logic uv_mask = 0, ov_dis = 0;
  logic [LOCK_W-1:0] lock_cfg = 6'd3;
  logic drv_off, restart;
  logic [1:0] flag;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fault_flag_mgr #(.LOCK_W(LOCK_W), .LOCK_UNIT(LOCK_UNIT), .BLANK_CYCLES(BLANK)) u_dut (
    .clk(clk), .rst(rst), .por_busy_i(por_busy), .tsd_i(tsd), .sync_lost_i(sync_lost),
    .ocp_i(ocp), .vbb_uv_i(vbb_uv), .vbb_ov_i(vbb_ov), .vcp_uv_i(vcp_uv),
    .run_cmd_i(run_cmd), .run_rise_i(run_rise), .cfg_uv_mask_i(uv_mask),
    .cfg_ov_dis_i(ov_dis), .cfg_lock_time_i(lock_cfg),
    .drv_off_o(drv_off), .restart_o(restart), .flag_o(flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // packed view {restart, drv_off, flag}
  function automatic int obs();
    return {restart, drv_off, flag};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    tick(2);
    chk("R12 reset state", obs(), 0);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_por_and_voltage();
    por_busy = 1; vbb_uv = 1;
    tick(1);
    chk("R11 por quiet", obs(), 4'b0100);
    por_busy = 0;
    tick(1);
    chk("R2 undervoltage flag", obs(), 4'b0111);
    vbb_uv = 0;
    tick(1);
    chk("R2 undervoltage released", obs(), 0);
    vbb_ov = 1;
    tick(1);
    chk("R2 overvoltage flag", obs(), 4'b0111);
    vbb_ov = 0;
    tick(1);
  endtask

  task automatic t_masks();
    uv_mask = 1; vbb_uv = 1;
    tick(1);
    chk("R4 uv mask keeps flag, no disable", obs(), 4'b0011);
    vbb_uv = 0; uv_mask = 0; ov_dis = 1; vbb_ov = 1;
    tick(1);
    chk("R4 ov disable ignores overvoltage", obs(), 0);
    vbb_ov = 0; ov_dis = 0;
    tick(1);
  endtask

  task automatic t_gate_uv();
    run_cmd = 0; vcp_uv = 1;
    tick(1);
    chk("R3 gate uv hidden when off", obs(), 4'b0100);
    run_cmd = 1;
    tick(1);
    chk("R3 gate uv shown when on", obs(), 4'b0111);
    vcp_uv = 0; run_cmd = 0;
    tick(1);
    chk("R3 gate uv released", obs(), 0);
  endtask

  task automatic t_thermal();
    int bad;
    run_cmd = 1; tsd = 1;
    tick(1);
    chk("R7 thermal first shows 01", flag, 2'b01);
    tick(1);
    chk("R7 thermal then shows 10", flag, 2'b10);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      tick(1);
      if (restart != 1'b0 || flag != 2'b10 || drv_off != 1'b1) bad++;
    end
    chk("R6 persistent thermal retriggers without restart", bad, 0);
    run_cmd = 0;
    tick(2);
    chk("R8 command off moves flag to thermal", obs(), 4'b0101);
    tsd = 0;
    tick(1);
    chk("R8 thermal released", obs(), 0);
  endtask

  task automatic t_lock(input logic [LOCK_W-1:0] cfg, input int n);
    int bad;
    lock_cfg = cfg;
    run_cmd = 1; sync_lost = 1;
    tick(1);
    sync_lost = 0;
    bad = 0;
    for (int k = 1; k <= n + 1; k++) begin
      tick(1);
      if (restart != (k == n)) bad++;
      if (flag != ((k <= n) ? 2'b10 : 2'b00)) bad++;
      if (drv_off != (k <= n)) bad++;
    end
    chk($sformatf("R5 lock timer of %0d clocks", n), bad, 0);
    run_cmd = 0;
    tick(2);
  endtask

  task automatic t_lock_abort();
    int seen;
    lock_cfg = 6'd3;
    run_cmd = 1; sync_lost = 1;
    tick(1);
    sync_lost = 0;
    tick(4);
    run_cmd = 0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      tick(1);
      if (restart) seen++;
    end
    chk("R8 command off blocks restart", seen, 0);
    chk("R8 timer cleared by command off", obs(), 0);
  endtask

  task automatic t_ocp();
    run_cmd = 1;
    ocp = 1;
    tick(2);
    ocp = 0;
    tick(3);
    chk("R9 short overcurrent ignored", obs(), 0);
    ocp = 1;
    tick(BLANK);
    chk("R9 not yet disabled at end of blanking", drv_off, 0);
    tick(1);
    chk("R9 overcurrent latched", obs(), 4'b0110);
    ocp = 0;
    tick(5);
    chk("R10 latch holds after release", obs(), 4'b0110);
    run_cmd = 0;
    tick(3);
    chk("R10 command off keeps latch", obs(), 4'b0110);
    vbb_uv = 1;
    tick(1);
    chk("R1 voltage over lead", flag, 2'b11);
    vbb_uv = 0; tsd = 1;
    tick(1);
    chk("R1 lead over thermal", flag, 2'b10);
    tsd = 0;
    run_cmd = 1; run_rise = 1;
    tick(1);
    run_rise = 0;
    tick(1);
    chk("R10 off-to-on clears latch", obs(), 0);
  endtask

  task automatic t_same_cycle();
    run_cmd = 1;
    ocp = 1;
    tick(BLANK - 1);
    run_rise = 1;
    tick(1);
    run_rise = 0; ocp = 0;
    tick(3);
    chk("R10 clear wins over trip in same cycle", obs(), 0);
    run_cmd = 0;
    tick(1);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_por_and_voltage();
    t_masks();
    t_gate_uv();
    t_thermal();
    t_lock(6'd3, 3 * LOCK_UNIT);
    t_lock(6'd0, LOCK_UNIT);
    t_lock_abort();
    t_ocp();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule